// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Port

This block accepts the configuration words of a frequency synthesizer over a three-wire serial link made of a serial clock, a serial data line and a load strobe. All three wires are brought into the system clock domain by a two-stage synchronizer, and the block detects their rising edges in that domain. Each rising edge of the serial clock seen while the load strobe is low shifts one data bit into a 20-bit shift path, most significant bit first.

When the load strobe rises, the two most recently shifted bits act as an address. One code selects a 17-bit reference divide register. Another selects an 18-bit main-divider register, which holds a 14-bit counter value and a 4-bit swallow value. The other two codes write nothing. Frames of 19 and 20 serial clocks share the same shift path. The chosen register is updated once, and a one-cycle update pulse for that register tells the divider logic downstream to take the new value.

Top module: `synth_prog_if`

## Requirements
- R1: Data is taken at rising edges of the serial clock only, most significant bit first. The register bit that receives a shifted bit depends only on how many bits were shifted after it.
- R2: A 19-clock frame (17 value bits, then select bits 1,1) followed by a load strobe makes `ref_div_o` equal to the 17 value bits, with the first-sent bit as bit 16.
- R3: A 20-clock frame (14 counter bits, 4 swallow bits, then select bits 0,1) followed by a load strobe makes `main_cnt_o` equal to the 14 counter bits and `main_swal_o` equal to the 4 swallow bits. The counter bits are the upper part of the word and the swallow bits are its lowest 4 bits.
- R4: Select codes 0,0 and 1,0 (last two bits shifted) write nothing. No output register changes and no update pulse is produced.
- R5: A write happens once per rising edge of the load strobe. Holding the strobe high for many cycles gives no second write. An update pulse appears three system clocks after the strobe is first sampled high.
- R6: Each write gives exactly one single-cycle pulse, on `ref_upd_o` or on `main_upd_o` according to the destination. The two pulses are never high together, and each pulse coincides with the new register value.
- R7: Serial clock edges are ignored while the load strobe is high. This includes a serial clock edge that is synchronized in the same cycle as the strobe's rising edge. That write uses the word as it stood before that edge.
- R8: Bits shifted before the last 20 fall out of the shift path. A frame preceded by extra bits writes the same value as the frame alone.
- R9: After synchronous reset, all three register outputs are zero and no update pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_load_i | input | 1 | Load strobe; low while shifting, rising edge writes |
| ref_div_o | output | 17 | Reference divide value |
| main_cnt_o | output | 14 | Main-divider counter value |
| main_swal_o | output | 4 | Main-divider swallow value |
| ref_upd_o | output | 1 | One-cycle pulse when the reference value is written |
| main_upd_o | output | 1 | One-cycle pulse when the main-divider word is written |

## Verification
A serial clock rising edge and a load strobe rising edge can be synchronized in the same system cycle. When that happens the block must choose between shifting and committing. The bench provokes this by raising both wires in the same instant, with a new data bit waiting on the line, after a complete reference frame. The write must carry the frame as it was before that edge, and the register must keep it through a later strobe. A second overlap is also checked: serial clocks issued while the strobe stays high must leave the shift path untouched, so a following strobe still decodes the reference code and rewrites the same value.

// File: rtl/synth_prog_pkg.sv
`timescale 1ns/1ps
package synth_prog_pkg;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int REF_W   = 17;
    localparam int CNT_W   = 14;
    localparam int SWAL_W  = 4;
    localparam int SEL_W   = 2;
    localparam int MAIN_W  = CNT_W + SWAL_W;
    localparam int SHIFT_W = max_of(REF_W, MAIN_W) + SEL_W;

    localparam logic [SEL_W-1:0] SEL_REF  = 2'b11;
    localparam logic [SEL_W-1:0] SEL_MAIN = 2'b01;

    typedef enum logic [1:0] {
        DEST_NONE = 2'd0,
        DEST_REF  = 2'd1,
        DEST_MAIN = 2'd2
    } dest_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [SWAL_W-1:0] swal;
    } main_word_t;

    function automatic dest_e decode_dest(input logic [SEL_W-1:0] code);
        if (code == SEL_REF)
            return DEST_REF;
        else if (code == SEL_MAIN)
            return DEST_MAIN;
        else
            return DEST_NONE;
    endfunction

endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
`timescale 1ns/1ps
module rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/frame_shifter.sv
`timescale 1ns/1ps
module frame_shifter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)
            word <= '0;
        else if (shift_en)
            word <= {word[W-2:0], bit_in};
    end
endmodule

// File: rtl/latch_bank.sv
`timescale 1ns/1ps
module latch_bank
    import synth_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic [SHIFT_W-1:0] word,
    output logic [REF_W-1:0]   ref_q,
    output main_word_t         main_q,
    output logic               ref_pulse,
    output logic               main_pulse
);
    dest_e dest;

    assign dest = decode_dest(word[SEL_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q      <= '0;
            main_q     <= '0;
            ref_pulse  <= 1'b0;
            main_pulse <= 1'b0;
        end else begin
            ref_pulse  <= 1'b0;
            main_pulse <= 1'b0;
            if (commit) begin
                unique case (dest)
                    DEST_REF: begin
                        ref_q     <= word[SEL_W +: REF_W];
                        ref_pulse <= 1'b1;
                    end
                    DEST_MAIN: begin
                        main_q     <= main_word_t'(word[SEL_W +: MAIN_W]);
                        main_pulse <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/synth_prog_if.sv
`timescale 1ns/1ps
module synth_prog_if
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              ser_load_i,
    output logic [REF_W-1:0]  ref_div_o,
    output logic [CNT_W-1:0]  main_cnt_o,
    output logic [SWAL_W-1:0] main_swal_o,
    output logic              ref_upd_o,
    output logic              main_upd_o
);
    localparam int LINES = 3;

    logic [LINES-1:0]   raw_lines, sync_lines;
    logic               sclk_lvl, sdata_lvl, load_lvl;
    logic               sclk_rise, load_rise, shift_en;
    logic [SHIFT_W-1:0] word;
    main_word_t         main_q;

    assign raw_lines = {ser_load_i, ser_data_i, ser_clk_i};

    bit_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    assign {load_lvl, sdata_lvl, sclk_lvl} = sync_lines;

    rise_detect u_sclk_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sclk_lvl),
        .rise (sclk_rise)
    );

    rise_detect u_load_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (load_lvl),
        .rise (load_rise)
    );

    assign shift_en = sclk_rise & ~load_lvl;

    frame_shifter #(.W(SHIFT_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_in   (sdata_lvl),
        .word     (word)
    );

    latch_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .commit     (load_rise),
        .word       (word),
        .ref_q      (ref_div_o),
        .main_q     (main_q),
        .ref_pulse  (ref_upd_o),
        .main_pulse (main_upd_o)
    );

    assign main_cnt_o  = main_q.cnt;
    assign main_swal_o = main_q.swal;
endmodule

// File: rtl/synth_prog_checker.sv
`timescale 1ns/1ps
module synth_prog_checker
    import synth_prog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ser_load_i,
    input logic [REF_W-1:0]  ref_div_o,
    input logic [CNT_W-1:0]  main_cnt_o,
    input logic [SWAL_W-1:0] main_swal_o,
    input logic              ref_upd_o,
    input logic              main_upd_o
);
    assert_ref_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
        ref_upd_o |=> !ref_upd_o);

    assert_main_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
        main_upd_o |=> !main_upd_o);

    assert_pulse_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(ref_upd_o && main_upd_o));

    assert_ref_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ref_upd_o |-> $stable(ref_div_o));

    assert_main_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !main_upd_o |-> ($stable(main_cnt_o) && $stable(main_swal_o)));

    assert_ref_after_load_R5: assert property (@(posedge clk) disable iff (rst)
        ref_upd_o |-> $past(ser_load_i, 3));

    assert_main_after_load_R5: assert property (@(posedge clk) disable iff (rst)
        main_upd_o |-> $past(ser_load_i, 3));
endmodule

bind synth_prog_if synth_prog_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .ser_load_i  (ser_load_i),
    .ref_div_o   (ref_div_o),
    .main_cnt_o  (main_cnt_o),
    .main_swal_o (main_swal_o),
    .ref_upd_o   (ref_upd_o),
    .main_upd_o  (main_upd_o)
);

// File: tb/test_synth_prog_if.sv
`timescale 1ns/1ps
module test_synth_prog_if;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_load = 1'b0;
    logic [16:0] ref_div;
    logic [13:0] main_cnt;
    logic [3:0]  main_swal;
    logic        ref_upd, main_upd;

    int n_tests = 0;
    int n_fail  = 0;
    int ref_pulses = 0, main_pulses = 0, overlap = 0;
    int exp_ref_n = 0, exp_main_n = 0;
    logic [16:0] exp_ref  = '0;
    logic [13:0] exp_cnt  = '0;
    logic [3:0]  exp_swal = '0;
    bit finished = 0;

    always #10 clk = ~clk;

    synth_prog_if i_synth_prog_if (
        .clk         (clk),
        .rst         (rst),
        .ser_clk_i   (ser_clk),
        .ser_data_i  (ser_data),
        .ser_load_i  (ser_load),
        .ref_div_o   (ref_div),
        .main_cnt_o  (main_cnt),
        .main_swal_o (main_swal),
        .ref_upd_o   (ref_upd),
        .main_upd_o  (main_upd)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ref_upd)  ref_pulses++;
            if (main_upd) main_pulses++;
            if (ref_upd && main_upd) overlap++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic strobe(input int hold);
        ser_load = 1'b1;
        wait_cyc(hold);
        ser_load = 1'b0;
        wait_cyc(8);
    endtask

    task automatic check_all(input string tag);
        check({tag, " ref"},  32'(ref_div),   32'(exp_ref));
        check({tag, " cnt"},  32'(main_cnt),  32'(exp_cnt));
        check({tag, " swal"}, 32'(main_swal), 32'(exp_swal));
        check({tag, " ref pulses R6"},  32'(ref_pulses),  32'(exp_ref_n));
        check({tag, " main pulses R6"}, 32'(main_pulses), 32'(exp_main_n));
    endtask

    task automatic send_ref(input logic [16:0] v);
        shift_bits(32'(v), 17);
        shift_bits(32'b11, 2);
        strobe(8);
        exp_ref = v;
        exp_ref_n++;
    endtask

    task automatic send_main(input logic [13:0] c, input logic [3:0] s);
        shift_bits(32'({c, s}), 18);
        shift_bits(32'b01, 2);
        strobe(8);
        exp_cnt  = c;
        exp_swal = s;
        exp_main_n++;
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(4);
        // R9 reset state
        check_all("R9 reset");

        // R2 / R1: walking ones through the reference word, MSB first
        for (int b = 0; b < 17; b++) begin
            send_ref(17'(1 << b));
            check_all("R2 R1 ref walk");
        end
        send_ref(17'h1FFFF); check_all("R2 ref all ones");
        send_ref(17'h15555); check_all("R2 ref pattern");
        send_ref(17'h00005); check_all("R2 ref small");

        // R3: full swallow sweep, derived counter values
        for (int s = 0; s < 16; s++) begin
            send_main(14'((s * 1237 + 272) & 14'h3FFF), 4'(s));
            check_all("R3 main sweep");
        end
        for (int b = 0; b < 14; b++) begin
            send_main(14'(1 << b), 4'(15 - (b % 16)));
            check_all("R3 R1 cnt walk");
        end

        // R4: codes 00 and 10 write nothing
        for (int k = 0; k < 2; k++) begin
            shift_bits(32'h3ABCD, 18);
            shift_bits(k == 0 ? 32'b00 : 32'b10, 2);
            strobe(8);
            check_all("R4 ignored code");
        end

        // R5: long strobe writes once; R7: clocks during strobe ignored
        shift_bits(32'h0ACE1, 17);
        shift_bits(32'b11, 2);
        ser_load = 1'b1;
        wait_cyc(40);
        exp_ref = 17'h0ACE1;
        exp_ref_n++;
        check_all("R5 long strobe single write");
        shift_bits(32'h0, 5);
        ser_load = 1'b0;
        wait_cyc(8);
        strobe(8);
        exp_ref_n++;
        check_all("R7 clocks while load high ignored");

        // R7: serial clock edge together with load rising edge
        shift_bits(32'h13579, 17);
        shift_bits(32'b11, 2);
        ser_data = 1'b0;
        wait_cyc(4);
        ser_clk  = 1'b1;
        ser_load = 1'b1;
        wait_cyc(8);
        ser_clk  = 1'b0;
        ser_load = 1'b0;
        wait_cyc(8);
        exp_ref = 17'h13579;
        exp_ref_n++;
        check_all("R7 collision write");
        strobe(8);
        exp_ref_n++;
        check_all("R7 collision word kept");

        // R8: leading junk bits fall out
        shift_bits(32'h1F, 5);
        send_main(14'h2A5C, 4'h9);
        check_all("R8 main with junk prefix");
        shift_bits(32'h3FF, 10);
        send_ref(17'h0F0F0);
        check_all("R8 ref with junk prefix");

        check("R6 no overlapping pulses", 32'(overlap), 32'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule